// File: doc/BRIEF.md
# Merging Write Buffer

This block sits between a cache and the next memory level and holds stores until memory takes them. Each entry covers one naturally aligned block of several consecutive data words. A new store whose block matches an entry that is still open is folded into that entry rather than taking a fresh slot, so a run of stores to neighbouring words leaves as one wide memory write with a mask that marks which words carry data.

Entries leave in the order they were opened. The oldest entry is offered to memory on a valid/ready handshake. From the cycle the offer starts, that entry is locked: its payload stays fixed and later stores to the same block open a new entry. A single partly filled entry is held back for a short merge window before it is offered. Loads only probe the buffer. The probe reports whether the addressed word is present and returns the newest copy.

With the default parameters there are four entries of four 64-bit words, so one entry spans 32 bytes.

Top module: `wbuf_merge`

## Requirements
- R1: After reset the buffer is empty: `st_ready` is 1, `mem_valid` is 0 and `ld_hit` is 0.
- R2: The word slot of an address is bits [4:3]. The entry address sent to memory is the store address with bits [4:0] cleared. Bits [2:0] are ignored.
- R3: Four stores to the four words of one block, for example addresses 100, 108, 116 and 124, end up in one entry. They leave as one transfer with address 96 and mask 4'b1111.
- R4: A store to a word that is already valid in an open matching entry replaces that word's data and leaves the mask unchanged.
- R5: When no open entry matches the store's block and all entries are occupied, `st_ready` is 0. No entry is added.
- R6: A store whose block matches an open entry is accepted even when all entries are occupied.
- R7: Entries are offered to memory in the order they were opened. An entry is removed on a cycle where `mem_valid` and `mem_ready` are both 1.
- R8: Once `mem_valid` rises, the head entry is locked. `mem_addr`, `mem_mask` and `mem_data` hold steady until the handshake completes. A store to the locked block opens a new entry.
- R9: An offer starts one cycle after one of these holds: more than one entry is occupied; the head mask is full; or a lone head has gone HOLD cycles without a write. With HOLD = 4, `mem_valid` rises on the fourth clock edge after the last store edge.
- R10: `ld_hit` is 1 only if some occupied entry holds the addressed block with that word's mask bit set. `ld_data` then returns the copy from the most recently opened such entry. Otherwise `ld_hit` is 0.
- R11: A transfer carries the entry address, all words and the mask together. Word w sits in `mem_data[64*w +: 64]` and mask bit w. Word positions whose mask bit is 0 are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Store request |
| st_ready | output | 1 | Store can be accepted this cycle |
| st_addr | input | 32 | Store byte address |
| st_data | input | 64 | Store data word |
| ld_addr | input | 32 | Load probe byte address |
| ld_hit | output | 1 | Probed word is present |
| ld_data | output | 64 | Newest copy of the probed word |
| mem_valid | output | 1 | Head entry offered to memory |
| mem_ready | input | 1 | Memory takes the offered entry |
| mem_addr | output | 32 | Block-aligned entry address |
| mem_data | output | 256 | All words of the entry, word 0 in the low bits |
| mem_mask | output | 4 | Per-word valid mask |

## Verification
The hardest state to reach is a full buffer with a locked head that shares its block with a younger entry. In that state a merge, a stall and a newest-copy load must all be told apart. The stimulus holds `mem_ready` low from the start of the scenario. It opens two blocks so an offer starts, then stores again to the locked block and fills the rest. Next it tries a store to an unseen block, merges into a younger entry, and probes the duplicated block. Finally the entries are drained one by one and their order and payloads are compared.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;
  typedef enum logic {
    DRN_IDLE = 1'b0,
    DRN_BUSY = 1'b1
  } drn_state_e;
endpackage

// File: rtl/wbuf_blk_match.sv
module wbuf_blk_match #(
  parameter int DEPTH = 4,
  parameter int AW    = 32
) (
  input  logic [DEPTH-1:0]         occ,
  input  logic [DEPTH-1:0]         lock,
  input  logic [DEPTH-1:0][AW-1:0] blk,
  input  logic [AW-1:0]            probe,
  output logic [DEPTH-1:0]         hit
);
  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    assign hit[i] = occ[i] && !lock[i] && (blk[i] == probe);
  end
endmodule

// File: rtl/wbuf_ld_pick.sv
module wbuf_ld_pick #(
  parameter int DEPTH = 4,
  parameter int WORDS = 4,
  parameter int DW    = 64,
  parameter int PW    = 2,
  parameter int SLOTW = 2
) (
  input  logic [DEPTH-1:0]                  blk_hit,
  input  logic [DEPTH-1:0][WORDS-1:0]       masks,
  input  logic [DEPTH-1:0][WORDS-1:0][DW-1:0] data,
  input  logic [PW-1:0]                     head,
  input  logic [SLOTW-1:0]                  slot,
  output logic                              hit,
  output logic [DW-1:0]                     word
);
  logic [PW-1:0] idx;
  // walk from oldest to newest so the youngest copy wins
  always_comb begin
    hit  = 1'b0;
    word = '0;
    idx  = head;
    for (int k = 0; k < DEPTH; k++) begin
      idx = head + PW'(k);
      if (blk_hit[idx] && masks[idx][slot]) begin
        hit  = 1'b1;
        word = data[idx][slot];
      end
    end
  end
endmodule

// File: rtl/wbuf_drain_ctl.sv
module wbuf_drain_ctl
  import wbuf_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int WORDS = 4,
  parameter int HOLD  = 4,
  parameter int CW    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CW-1:0]    count,
  input  logic [WORDS-1:0] head_mask,
  input  logic             head_wr,
  input  logic             mem_ready,
  output logic             busy,
  output logic             pop,
  output logic             start
);
  localparam int AGW = $clog2(HOLD + 1);

  drn_state_e      state;
  logic [AGW-1:0]  age;
  logic            age_due;

  assign age_due = (age >= AGW'(HOLD - 1));
  assign start   = (state == DRN_IDLE) && (count != '0) &&
                   ((count > CW'(1)) || (&head_mask) || age_due);
  assign busy    = (state == DRN_BUSY);
  assign pop     = busy && mem_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= DRN_IDLE;
      age   <= '0;
    end else begin
      if (start)    state <= DRN_BUSY;
      else if (pop) state <= DRN_IDLE;
      if (pop || head_wr || count == '0) age <= '0;
      else if (age != AGW'(HOLD))        age <= age + AGW'(1);
    end
  end

  p_busy_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !mem_ready |=> busy);
  p_offer_nonempty_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> count != '0);
  p_start_after_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);
endmodule

// File: rtl/wbuf_merge.sv
module wbuf_merge
  import wbuf_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DW    = 64,
  parameter int WORDS = 4,
  parameter int DEPTH = 4,
  parameter int HOLD  = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                st_valid,
  output logic                st_ready,
  input  logic [AW-1:0]       st_addr,
  input  logic [DW-1:0]       st_data,
  input  logic [AW-1:0]       ld_addr,
  output logic                ld_hit,
  output logic [DW-1:0]       ld_data,
  output logic                mem_valid,
  input  logic                mem_ready,
  output logic [AW-1:0]       mem_addr,
  output logic [WORDS*DW-1:0] mem_data,
  output logic [WORDS-1:0]    mem_mask
);
  localparam int BYTEW = $clog2(DW / 8);
  localparam int SLOTW = $clog2(WORDS);
  localparam int OFFW  = BYTEW + SLOTW;
  localparam int PW    = $clog2(DEPTH);
  localparam int CW    = PW + 1;

  function automatic logic [AW-1:0] blk_of(input logic [AW-1:0] a);
    logic [AW-1:0] r;
    r = a;
    r[OFFW-1:0] = '0;
    return r;
  endfunction

  function automatic logic [SLOTW-1:0] slot_of(input logic [AW-1:0] a);
    return a[OFFW-1:BYTEW];
  endfunction

  function automatic logic [PW-1:0] enc(input logic [DEPTH-1:0] v);
    logic [PW-1:0] r;
    r = '0;
    for (int i = 0; i < DEPTH; i++) if (v[i]) r = PW'(i);
    return r;
  endfunction

  logic [DEPTH-1:0]                    e_occ;
  logic [DEPTH-1:0][AW-1:0]            e_blk;
  logic [DEPTH-1:0][WORDS-1:0]         e_mask;
  logic [DEPTH-1:0][WORDS-1:0][DW-1:0] e_data;
  logic [PW-1:0]                       head, tail;
  logic [CW-1:0]                       count;

  logic [AW-1:0]    st_blk, ld_blk;
  logic [SLOTW-1:0] st_slot, ld_slot;
  logic [DEPTH-1:0] lock_vec, st_hit_vec, ld_hit_vec;
  logic             st_merge, st_fire, st_alloc, head_wr;
  logic [PW-1:0]    wr_idx;
  logic             drain_busy, pop, drain_start;

  assign st_blk  = blk_of(st_addr);
  assign st_slot = slot_of(st_addr);
  assign ld_blk  = blk_of(ld_addr);
  assign ld_slot = slot_of(ld_addr);

  always_comb begin
    lock_vec = '0;
    if (drain_busy) lock_vec[head] = 1'b1;
  end

  wbuf_blk_match #(.DEPTH(DEPTH), .AW(AW)) u_st_match (
    .occ(e_occ), .lock(lock_vec), .blk(e_blk), .probe(st_blk), .hit(st_hit_vec)
  );

  wbuf_blk_match #(.DEPTH(DEPTH), .AW(AW)) u_ld_match (
    .occ(e_occ), .lock('0), .blk(e_blk), .probe(ld_blk), .hit(ld_hit_vec)
  );

  wbuf_ld_pick #(.DEPTH(DEPTH), .WORDS(WORDS), .DW(DW), .PW(PW), .SLOTW(SLOTW)) u_ld_pick (
    .blk_hit(ld_hit_vec), .masks(e_mask), .data(e_data), .head(head),
    .slot(ld_slot), .hit(ld_hit), .word(ld_data)
  );

  assign st_merge = |st_hit_vec;
  assign st_ready = st_merge || (count < CW'(DEPTH));
  assign st_fire  = st_valid && st_ready;
  assign st_alloc = st_fire && !st_merge;
  assign wr_idx   = st_merge ? enc(st_hit_vec) : tail;
  assign head_wr  = st_fire && (wr_idx == head);

  wbuf_drain_ctl #(.DEPTH(DEPTH), .WORDS(WORDS), .HOLD(HOLD), .CW(CW)) u_drain (
    .clk(clk), .rst_n(rst_n), .count(count), .head_mask(e_mask[head]),
    .head_wr(head_wr), .mem_ready(mem_ready), .busy(drain_busy), .pop(pop),
    .start(drain_start)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      e_occ  <= '0;
      e_blk  <= '0;
      e_mask <= '0;
      e_data <= '0;
      head   <= '0;
      tail   <= '0;
      count  <= '0;
    end else begin
      if (pop) begin
        e_occ[head] <= 1'b0;
        head        <= head + PW'(1);
      end
      if (st_alloc) begin
        e_occ[tail]  <= 1'b1;
        e_blk[tail]  <= st_blk;
        e_mask[tail] <= WORDS'(1) << st_slot;
        for (int w = 0; w < WORDS; w++)
          e_data[tail][w] <= (SLOTW'(w) == st_slot) ? st_data : '0;
        tail <= tail + PW'(1);
      end
      if (st_fire && st_merge) begin
        e_mask[wr_idx][st_slot] <= 1'b1;
        e_data[wr_idx][st_slot] <= st_data;
      end
      count <= count + CW'(st_alloc) - CW'(pop);
    end
  end

  assign mem_valid = drain_busy;
  assign mem_addr  = e_blk[head];
  assign mem_mask  = e_mask[head];
  assign mem_data  = e_data[head];

  p_empty_ready_r1: assert property (@(posedge clk) disable iff (!rst_n)
    count == '0 |-> st_ready && !ld_hit);
  p_single_target_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(st_hit_vec));
  p_count_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  p_stall_only_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !st_ready |-> count == CW'(DEPTH));
  p_payload_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) &&
    $stable(mem_mask) && $stable(mem_data));
  p_offer_has_data_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> mem_mask != '0);
  p_hit_needs_entry_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ld_hit |-> count != '0);
endmodule

// File: tb/wbuf_merge_test.sv
`timescale 1ns/1ps
module wbuf_merge_test;
  localparam int HOLD = 4;
  logic clk = 1'b0, rst_n = 1'b0;
  logic st_valid = 1'b0, st_ready;
  logic [31:0] st_addr = '0, ld_addr = '0, mem_addr;
  logic [63:0] st_data = '0, ld_data;
  logic ld_hit, mem_valid, mem_ready = 1'b0;
  logic [255:0] mem_data;
  logic [3:0] mem_mask;
  int n_cmp = 0, n_bad = 0;

  always #4 clk = ~clk;

  wbuf_merge #(.HOLD(HOLD)) uut (
    .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_ready(st_ready),
    .st_addr(st_addr), .st_data(st_data), .ld_addr(ld_addr), .ld_hit(ld_hit),
    .ld_data(ld_data), .mem_valid(mem_valid), .mem_ready(mem_ready),
    .mem_addr(mem_addr), .mem_data(mem_data), .mem_mask(mem_mask)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic do_store(input logic [31:0] a, input logic [63:0] d);
    int w;
    @(negedge clk);
    st_valid = 1'b1; st_addr = a; st_data = d;
    w = 0;
    while (!st_ready && w < 50) begin @(negedge clk); w++; end
    @(negedge clk);
    st_valid = 1'b0;
  endtask

  task automatic probe(input logic [31:0] a, input bit exp_hit,
                       input logic [63:0] exp_d, input string req);
    ld_addr = a;
    #1;
    chk(ld_hit == exp_hit, req, "load hit", 64'(ld_hit), 64'(exp_hit));
    if (exp_hit) chk(ld_data == exp_d, req, "load data", ld_data, exp_d);
  endtask

  task automatic drain_expect(input logic [31:0] a, input logic [3:0] m,
                              input logic [63:0] w0, w1, w2, w3, input string req);
    int t;
    t = 0;
    while (!mem_valid && t < 40) begin @(negedge clk); t++; end
    chk(mem_valid, req, "offer appears", 64'(mem_valid), 64'd1);
    chk(mem_addr == a, req, "entry address", 64'(mem_addr), 64'(a));
    chk(mem_mask == m, req, "mask", 64'(mem_mask), 64'(m));
    chk(mem_data[0 +: 64] == w0, req, "word0", mem_data[0 +: 64], w0);
    chk(mem_data[64 +: 64] == w1, req, "word1", mem_data[64 +: 64], w1);
    chk(mem_data[128 +: 64] == w2, req, "word2", mem_data[128 +: 64], w2);
    chk(mem_data[192 +: 64] == w3, req, "word3", mem_data[192 +: 64], w3);
    mem_ready = 1'b1;
    @(negedge clk);
    mem_ready = 1'b0;
  endtask

  task automatic t_reset;
    #1;
    chk(st_ready == 1'b1, "R1", "st_ready", 64'(st_ready), 64'd1);
    chk(mem_valid == 1'b0, "R1", "mem_valid", 64'(mem_valid), 64'd0);
    probe(32'h0, 1'b0, '0, "R1");
  endtask

  // R2 R3: four neighbouring stores become one transfer
  task automatic t_merge_seq;
    do_store(32'd100, 64'h1111);
    do_store(32'd108, 64'h2222);
    do_store(32'd116, 64'h3333);
    do_store(32'd124, 64'h4444);
    chk(mem_valid == 1'b0, "R9", "full mask not yet offered", 64'(mem_valid), 64'd0);
    @(negedge clk);
    chk(mem_valid == 1'b1, "R9", "full mask offered next edge", 64'(mem_valid), 64'd1);
    probe(32'd117, 1'b1, 64'h3333, "R2");
    drain_expect(32'd96, 4'hF, 64'h1111, 64'h2222, 64'h3333, 64'h4444, "R3");
  endtask

  // R4 R11: overwrite keeps mask, empty words are zero
  task automatic t_overwrite;
    do_store(32'h208, 64'hAAAA);
    do_store(32'h20C, 64'hBBBB);
    probe(32'h208, 1'b1, 64'hBBBB, "R4");
    probe(32'h200, 1'b0, '0, "R10");
    drain_expect(32'h200, 4'b0010, 64'h0, 64'hBBBB, 64'h0, 64'h0, "R4");
  endtask

  // R9: lone partial entry waits HOLD edges
  task automatic t_hold;
    do_store(32'h318, 64'h5555);
    for (int i = 0; i < HOLD; i++) begin
      chk(mem_valid == 1'b0, "R9", "held during merge window", 64'(mem_valid), 64'd0);
      @(negedge clk);
    end
    chk(mem_valid == 1'b1, "R9", "offered after window", 64'(mem_valid), 64'd1);
    drain_expect(32'h300, 4'b1000, 64'h0, 64'h0, 64'h0, 64'h5555, "R11");
  endtask

  // R5 R6 R7 R8 R10: full buffer with a locked head
  task automatic t_full_lock;
    int t;
    do_store(32'h400, 64'hA0);
    do_store(32'h420, 64'hB0);
    t = 0;
    while (!mem_valid && t < 20) begin @(negedge clk); t++; end
    chk(mem_addr == 32'h400, "R8", "head offered", 64'(mem_addr), 64'h400);
    do_store(32'h408, 64'hC1);
    chk(mem_mask == 4'b0001, "R8", "locked head mask", 64'(mem_mask), 64'h1);
    probe(32'h408, 1'b1, 64'hC1, "R10");
    do_store(32'h440, 64'hD0);
    @(negedge clk);
    st_valid = 1'b1; st_addr = 32'h460; st_data = 64'hEE;
    #1;
    chk(st_ready == 1'b0, "R5", "stall when full", 64'(st_ready), 64'd0);
    @(negedge clk);
    chk(st_ready == 1'b0, "R5", "still stalled", 64'(st_ready), 64'd0);
    st_valid = 1'b0;
    st_addr = 32'h428;
    #1;
    chk(st_ready == 1'b1, "R6", "merge ready when full", 64'(st_ready), 64'd1);
    do_store(32'h428, 64'hB1);
    do_store(32'h400, 64'hF0);
    probe(32'h400, 1'b1, 64'hF0, "R10");
    probe(32'h430, 1'b0, '0, "R10");
    chk(mem_data[0 +: 64] == 64'hA0, "R8", "locked payload kept", mem_data[0 +: 64], 64'hA0);
    drain_expect(32'h400, 4'b0001, 64'hA0, 64'h0, 64'h0, 64'h0, "R7");
    drain_expect(32'h420, 4'b0011, 64'hB0, 64'hB1, 64'h0, 64'h0, "R7");
    drain_expect(32'h400, 4'b0011, 64'hF0, 64'hC1, 64'h0, 64'h0, "R7");
    drain_expect(32'h440, 4'b0001, 64'hD0, 64'h0, 64'h0, 64'h0, "R7");
    @(negedge clk);
    probe(32'h440, 1'b0, '0, "R10");
    chk(mem_valid == 1'b0, "R7", "empty after drain", 64'(mem_valid), 64'd0);
  endtask

  initial begin
    #(8 * 100000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_merge_seq();
    t_overwrite();
    t_hold();
    t_full_lock();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule